// File: doc/BRIEF.md
# Atomic Read-Modify-Write Datapath

This block computes the value to store back to memory for a read-modify-write atomic access. The caller presents the value read from memory, the register operand, a 5-bit operation code and a width select that picks a full 64-bit access or a 32-bit word access. One cycle later, the block returns two values: the value to write back, and the value for the destination register.

The destination register always receives the loaded value. In word mode that value is sign-extended from bit 31. The write-back value depends on the operation. There are nine operations: add, swap, three bitwise operations, and signed and unsigned minimum and maximum. In word mode every operation works on the low 32 bits and the result is sign-extended to 64 bits.

Two codes, load-reserved and store-conditional, are only flagged, so that a separate reservation unit can act on them. Any other code is reported as illegal.

Top module: `amo_datapath`

## Requirements
- R1: While reset is held, out_valid, illegal_op, is_lr and is_sc are 0 and wb_data and rd_data are 0. Each cycle with in_valid high produces out_valid high exactly one clock later. A cycle without in_valid produces out_valid low one clock later, so an isolated strobe gives a one-cycle pulse.
- R2: rd_data equals mem_old when is_word is 0. When is_word is 1, it equals mem_old[31:0] sign-extended from bit 31.
- R3: Code 5'h00 writes back old + operand, wrapping modulo 2^64. Code 5'h01 writes back the operand.
- R4: Code 5'h04 writes back old XOR operand, code 5'h08 writes back old OR operand, and code 5'h0C writes back old AND operand.
- R5: Code 5'h10 writes back the signed minimum of old and operand. Code 5'h14 writes back the signed maximum.
- R6: Code 5'h18 writes back the unsigned minimum of old and operand. Code 5'h1C writes back the unsigned maximum.
- R7: With is_word = 1, bits 63:32 of both inputs have no effect. The operation uses the low 32 bits, minimum and maximum compare them as 32-bit signed or unsigned numbers, and wb_data is the 32-bit result sign-extended to 64 bits.
- R8: Code 5'h02 sets is_lr and code 5'h03 sets is_sc. For both codes illegal_op is 0 and wb_data equals rd_data.
- R9: Any code other than the eleven listed above sets illegal_op, clears is_lr and is_sc, and makes wb_data equal to rd_data.
- R10: In a cycle without in_valid, wb_data, rd_data and the three flags keep the values from the last accepted strobe, whatever the data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Strobe marking a new operation on the inputs |
| op_code | input | 5 | Operation code |
| is_word | input | 1 | 1 selects a 32-bit word access, 0 a 64-bit access |
| mem_old | input | 64 | Value read from memory |
| reg_src | input | 64 | Register operand |
| out_valid | output | 1 | Result strobe, one cycle after in_valid |
| wb_data | output | 64 | Value to write back to memory |
| rd_data | output | 64 | Value for the destination register |
| illegal_op | output | 1 | Operation code is not supported |
| is_lr | output | 1 | Operation is load-reserved |
| is_sc | output | 1 | Operation is store-conditional |

## Verification
Every result (wb_data, rd_data, the three flags and out_valid) comes from a single register stage. All of them are therefore due at the first rising edge after the cycle in which in_valid is high. The bench drives each operation just after a falling edge and drops in_valid at the next falling edge. At that same falling edge it compares every output, half a period after the register has loaded.

At the following falling edge, the bench checks that out_valid has gone low. It also checks that the data and flags have held, even though it drove fresh random values onto the data inputs. A back-to-back pair of strobes is checked edge by edge, to confirm that the second result arrives exactly one cycle after the first.

// File: rtl/amo_pkg.sv
package amo_pkg;

  localparam int OPW = 5;

  // Operation codes as seen on op_code
  localparam logic [OPW-1:0] OPC_ADD  = 5'h00;
  localparam logic [OPW-1:0] OPC_SWAP = 5'h01;
  localparam logic [OPW-1:0] OPC_LR   = 5'h02;
  localparam logic [OPW-1:0] OPC_SC   = 5'h03;
  localparam logic [OPW-1:0] OPC_XOR  = 5'h04;
  localparam logic [OPW-1:0] OPC_OR   = 5'h08;
  localparam logic [OPW-1:0] OPC_AND  = 5'h0C;
  localparam logic [OPW-1:0] OPC_MIN  = 5'h10;
  localparam logic [OPW-1:0] OPC_MAX  = 5'h14;
  localparam logic [OPW-1:0] OPC_MINU = 5'h18;
  localparam logic [OPW-1:0] OPC_MAXU = 5'h1C;

  // Internal function select for the compute stage
  typedef enum logic [3:0] {
    FN_ADD, FN_SWAP, FN_XOR, FN_OR, FN_AND,
    FN_MIN, FN_MAX, FN_MINU, FN_MAXU, FN_KEEP
  } amo_fn_e;

  typedef struct packed {
    amo_fn_e fn;
    logic    illegal;
    logic    lr;
    logic    sc;
  } amo_ctrl_t;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [OPW-1:0] op_code,
  output amo_ctrl_t      ctrl
);

  always_comb begin
    ctrl.fn      = FN_KEEP;
    ctrl.illegal = 1'b0;
    ctrl.lr      = 1'b0;
    ctrl.sc      = 1'b0;
    case (op_code)
      OPC_ADD:  ctrl.fn = FN_ADD;
      OPC_SWAP: ctrl.fn = FN_SWAP;
      OPC_XOR:  ctrl.fn = FN_XOR;
      OPC_OR:   ctrl.fn = FN_OR;
      OPC_AND:  ctrl.fn = FN_AND;
      OPC_MIN:  ctrl.fn = FN_MIN;
      OPC_MAX:  ctrl.fn = FN_MAX;
      OPC_MINU: ctrl.fn = FN_MINU;
      OPC_MAXU: ctrl.fn = FN_MAXU;
      OPC_LR:   ctrl.lr = 1'b1;
      OPC_SC:   ctrl.sc = 1'b1;
      default:  ctrl.illegal = 1'b1;
    endcase
  end

endmodule

// File: rtl/amo_size_ext.sv
module amo_size_ext #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic            is_word,
  input  logic [XLEN-1:0] din,
  output logic [XLEN-1:0] dout
);

  localparam int HI = XLEN - WLEN;

  generate
    if (HI > 0) begin : g_ext
      logic [XLEN-1:0] narrow;
      assign narrow = {{HI{din[WLEN-1]}}, din[WLEN-1:0]};
      assign dout   = is_word ? narrow : din;
    end else begin : g_pass
      assign dout = din;
    end
  endgenerate

endmodule

// File: rtl/amo_compute.sv
module amo_compute
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_fn_e         fn,
  input  logic [XLEN-1:0] old_v,
  input  logic [XLEN-1:0] src_v,
  output logic [XLEN-1:0] res
);

  localparam int MSB = XLEN - 1;

  // One shared subtractor serves both signed and unsigned ordering.
  logic [XLEN:0]   diff;
  logic            lt_u;
  logic            lt_s;
  logic [XLEN-1:0] sum;

  assign diff = {1'b0, old_v} - {1'b0, src_v};
  assign lt_u = diff[XLEN];
  assign lt_s = (old_v[MSB] != src_v[MSB]) ? old_v[MSB] : lt_u;
  assign sum  = old_v + src_v;

  always_comb begin
    case (fn)
      FN_ADD:  res = sum;
      FN_SWAP: res = src_v;
      FN_XOR:  res = old_v ^ src_v;
      FN_OR:   res = old_v | src_v;
      FN_AND:  res = old_v & src_v;
      FN_MIN:  res = lt_s ? old_v : src_v;
      FN_MAX:  res = lt_s ? src_v : old_v;
      FN_MINU: res = lt_u ? old_v : src_v;
      FN_MAXU: res = lt_u ? src_v : old_v;
      default: res = old_v;
    endcase
  end

endmodule

// File: rtl/amo_datapath.sv
module amo_datapath
  import amo_pkg::*;
#(
  parameter int XLEN       = 64,
  parameter int WLEN       = 32,
  parameter int RST_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [4:0]      op_code,
  input  logic            is_word,
  input  logic [XLEN-1:0] mem_old,
  input  logic [XLEN-1:0] reg_src,
  output logic            out_valid,
  output logic [XLEN-1:0] wb_data,
  output logic [XLEN-1:0] rd_data,
  output logic            illegal_op,
  output logic            is_lr,
  output logic            is_sc
);

  // Reset: asserted asynchronously, released on the clock
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_pipe[RST_STAGES-1];

  // Datapath
  amo_ctrl_t       ctrl;
  logic [XLEN-1:0] old_x;
  logic [XLEN-1:0] src_x;
  logic [XLEN-1:0] raw_res;
  logic [XLEN-1:0] res_x;

  amo_decode u_dec (
    .op_code (op_code),
    .ctrl    (ctrl)
  );

  amo_size_ext #(.XLEN(XLEN), .WLEN(WLEN)) u_ext_old (
    .is_word (is_word),
    .din     (mem_old),
    .dout    (old_x)
  );

  amo_size_ext #(.XLEN(XLEN), .WLEN(WLEN)) u_ext_src (
    .is_word (is_word),
    .din     (reg_src),
    .dout    (src_x)
  );

  amo_compute #(.XLEN(XLEN)) u_alu (
    .fn    (ctrl.fn),
    .old_v (old_x),
    .src_v (src_x),
    .res   (raw_res)
  );

  amo_size_ext #(.XLEN(XLEN), .WLEN(WLEN)) u_ext_res (
    .is_word (is_word),
    .din     (raw_res),
    .dout    (res_x)
  );

  // Next-state
  logic            vld_d;
  logic            cap_en;
  logic [XLEN-1:0] wb_d;
  logic [XLEN-1:0] rd_d;
  logic            ill_d;
  logic            lr_d;
  logic            sc_d;

  always_comb begin
    vld_d  = in_valid;
    cap_en = in_valid;
    wb_d   = res_x;
    rd_d   = old_x;
    ill_d  = ctrl.illegal;
    lr_d   = ctrl.lr;
    sc_d   = ctrl.sc;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_data    <= '0;
      rd_data    <= '0;
      illegal_op <= 1'b0;
      is_lr      <= 1'b0;
      is_sc      <= 1'b0;
    end else if (cap_en) begin
      wb_data    <= wb_d;
      rd_data    <= rd_d;
      illegal_op <= ill_d;
      is_lr      <= lr_d;
      is_sc      <= sc_d;
    end
  end

endmodule

// File: rtl/amo_datapath_chk.sv
module amo_datapath_chk #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input logic            clk,
  input logic            rst_ni,
  input logic            in_valid,
  input logic [4:0]      op_code,
  input logic            is_word,
  input logic [XLEN-1:0] mem_old,
  input logic [XLEN-1:0] reg_src,
  input logic            out_valid,
  input logic [XLEN-1:0] wb_data,
  input logic [XLEN-1:0] rd_data,
  input logic            illegal_op,
  input logic            is_lr,
  input logic            is_sc
);

  localparam int HI = XLEN - WLEN;

  function automatic logic [XLEN-1:0] sx(input logic [XLEN-1:0] v);
    return {{HI{v[WLEN-1]}}, v[WLEN-1:0]};
  endfunction

  p_strobe_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |=> out_valid);

  p_pulse_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> !out_valid);

  p_rd_old_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |=> rd_data == ($past(is_word) ? sx($past(mem_old)) : $past(mem_old)));

  p_swap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && op_code == 5'h01 && !is_word) |=> wb_data == $past(reg_src));

  p_minmax_pick_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && op_code[4] && op_code[1:0] == 2'b00 && !is_word)
      |=> (wb_data == $past(mem_old) || wb_data == $past(reg_src)));

  p_word_sext_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (in_valid && is_word) |=> wb_data == sx(wb_data));

  p_resv_keep_r8: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && (is_lr || is_sc)) |-> (wb_data == rd_data && !illegal_op));

  p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $onehot0({illegal_op, is_lr, is_sc}));

  p_illegal_keep_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    (out_valid && illegal_op) |-> wb_data == rd_data);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> ($stable(wb_data) && $stable(rd_data) && $stable(illegal_op)));

endmodule

bind amo_datapath amo_datapath_chk #(.XLEN(XLEN), .WLEN(WLEN)) u_chk (
  .clk        (clk),
  .rst_ni     (rst_ni),
  .in_valid   (in_valid),
  .op_code    (op_code),
  .is_word    (is_word),
  .mem_old    (mem_old),
  .reg_src    (reg_src),
  .out_valid  (out_valid),
  .wb_data    (wb_data),
  .rd_data    (rd_data),
  .illegal_op (illegal_op),
  .is_lr      (is_lr),
  .is_sc      (is_sc)
);

// File: tb/amo_datapath_test.sv
module amo_datapath_test;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [4:0]  op_code;
  logic        is_word;
  logic [63:0] mem_old;
  logic [63:0] reg_src;
  logic        out_valid;
  logic [63:0] wb_data;
  logic [63:0] rd_data;
  logic        illegal_op;
  logic        is_lr;
  logic        is_sc;

  int n_chk;
  int n_bad;
  bit done;

  amo_datapath uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
    .is_word(is_word), .mem_old(mem_old), .reg_src(reg_src),
    .out_valid(out_valid), .wb_data(wb_data), .rd_data(rd_data),
    .illegal_op(illegal_op), .is_lr(is_lr), .is_sc(is_sc)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Reference model
  function automatic logic [63:0] m_rd(input logic w, input logic [63:0] o);
    return w ? {{32{o[31]}}, o[31:0]} : o;
  endfunction

  function automatic bit m_known(input logic [4:0] op);
    return op inside {5'h00, 5'h01, 5'h04, 5'h08, 5'h0C,
                      5'h10, 5'h14, 5'h18, 5'h1C};
  endfunction

  function automatic logic [63:0] m_wb(input logic [4:0] op, input logic w,
                                       input logic [63:0] o, input logic [63:0] s);
    logic [31:0] o32, s32, r32;
    logic [63:0] r;
    if (!m_known(op)) return m_rd(w, o);
    if (w) begin
      o32 = o[31:0]; s32 = s[31:0];
      case (op)
        5'h00: r32 = o32 + s32;
        5'h01: r32 = s32;
        5'h04: r32 = o32 ^ s32;
        5'h08: r32 = o32 | s32;
        5'h0C: r32 = o32 & s32;
        5'h10: r32 = ($signed(o32) < $signed(s32)) ? o32 : s32;
        5'h14: r32 = ($signed(o32) > $signed(s32)) ? o32 : s32;
        5'h18: r32 = (o32 < s32) ? o32 : s32;
        default: r32 = (o32 > s32) ? o32 : s32;
      endcase
      return {{32{r32[31]}}, r32};
    end
    case (op)
      5'h00: r = o + s;
      5'h01: r = s;
      5'h04: r = o ^ s;
      5'h08: r = o | s;
      5'h0C: r = o & s;
      5'h10: r = ($signed(o) < $signed(s)) ? o : s;
      5'h14: r = ($signed(o) > $signed(s)) ? o : s;
      5'h18: r = (o < s) ? o : s;
      default: r = (o > s) ? o : s;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [4:0] op, input logic w);
    if (w && m_known(op)) return "R7";
    case (op)
      5'h00, 5'h01: return "R3";
      5'h04, 5'h08, 5'h0C: return "R4";
      5'h10, 5'h14: return "R5";
      5'h18, 5'h1C: return "R6";
      5'h02, 5'h03: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run_vec(input logic [4:0] op, input logic w,
                         input logic [63:0] o, input logic [63:0] s);
    logic [63:0] ewb, erd;
    string tg;
    ewb = m_wb(op, w, o, s);
    erd = m_rd(w, o);
    tg  = tag_of(op, w);
    @(negedge clk);
    in_valid = 1'b1; op_code = op; is_word = w; mem_old = o; reg_src = s;
    @(negedge clk);
    in_valid = 1'b0;
    op_code = 5'($urandom); is_word = 1'($urandom);
    mem_old = {$urandom, $urandom}; reg_src = {$urandom, $urandom};
    chk(out_valid == 1'b1, "R1", "out_valid after strobe", 64'(out_valid), 64'd1);
    chk(wb_data == ewb, tg, $sformatf("wb op=%h w=%0d", op, w), wb_data, ewb);
    chk(rd_data == erd, "R2", $sformatf("rd op=%h w=%0d", op, w), rd_data, erd);
    chk(illegal_op == !(m_known(op) || op == 5'h02 || op == 5'h03), tg, "illegal_op",
        64'(illegal_op), 64'(!(m_known(op) || op == 5'h02 || op == 5'h03)));
    chk(is_lr == (op == 5'h02), "R8", "is_lr", 64'(is_lr), 64'(op == 5'h02));
    chk(is_sc == (op == 5'h03), "R8", "is_sc", 64'(is_sc), 64'(op == 5'h03));
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "out_valid pulse end", 64'(out_valid), 64'd0);
    chk(wb_data == ewb, "R10", "wb hold", wb_data, ewb);
    chk(rd_data == erd, "R10", "rd hold", rd_data, erd);
  endtask

  function automatic logic [63:0] pick_data();
    case ($urandom % 6)
      0: return {$urandom, $urandom};
      1: return 64'h0000_0000_8000_0000 | 64'($urandom % 4);
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h8000_0000_0000_0000;
      4: return 64'($urandom % 16);
      default: return {$urandom, 32'h7FFF_FFFF};
    endcase
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] ops [9];
    ops = '{5'h00, 5'h01, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C};
    n_chk = 0; n_bad = 0; done = 1'b0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op_code = '0; is_word = 1'b0;
    mem_old = '0; reg_src = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "reset out_valid", 64'(out_valid), 64'd0);
    chk(wb_data == 64'd0, "R1", "reset wb_data", wb_data, 64'd0);
    chk(rd_data == 64'd0, "R1", "reset rd_data", rd_data, 64'd0);
    chk({illegal_op, is_lr, is_sc} == 3'b000, "R1", "reset flags",
        64'({illegal_op, is_lr, is_sc}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Directed corners
    run_vec(5'h00, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);               // R3 wrap
    run_vec(5'h01, 1'b0, 64'h1234_5678_9ABC_DEF0, 64'hDEAD_BEEF_0000_0001);
    run_vec(5'h04, 1'b0, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);  // R4
    run_vec(5'h10, 1'b0, 64'h8000_0000_0000_0000, 64'd5);               // R5
    run_vec(5'h14, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run_vec(5'h18, 1'b0, 64'h8000_0000_0000_0000, 64'd5);               // R6
    run_vec(5'h1C, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);
    run_vec(5'h00, 1'b1, 64'hAAAA_AAAA_7FFF_FFFF, 64'h5555_5555_0000_0001); // R7
    run_vec(5'h10, 1'b1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0001);
    run_vec(5'h1C, 1'b1, 64'h0000_0000_8000_0000, 64'h0000_0001_7FFF_FFFF);
    run_vec(5'h02, 1'b0, 64'h1111_2222_3333_4444, 64'h9);               // R8
    run_vec(5'h03, 1'b1, 64'h1111_2222_F333_4444, 64'h9);
    run_vec(5'h1F, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h77);              // R9
    run_vec(5'h05, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h77);

    // R1: back-to-back strobes
    @(negedge clk);
    in_valid = 1'b1; op_code = 5'h08; is_word = 1'b0;
    mem_old = 64'h0F; reg_src = 64'hF0;
    @(negedge clk);
    chk(out_valid == 1'b1 && wb_data == 64'hFF, "R1", "first of pair", wb_data, 64'hFF);
    op_code = 5'h0C; mem_old = 64'h3C; reg_src = 64'h0F;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1 && wb_data == 64'h0C, "R1", "second of pair", wb_data, 64'h0C);
    @(negedge clk);
    chk(out_valid == 1'b0, "R1", "pair end", 64'(out_valid), 64'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [4:0] op;
      if ($urandom % 4 == 0) op = 5'($urandom);
      else op = ops[$urandom % 9];
      run_vec(op, 1'($urandom), pick_data(), pick_data());
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule